// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block turns up to eight external interrupt pins into pending flags and interrupt requests. Each pin is first brought into the clock domain by a two-flop synchronizer. A per-pin detector then sets a pending flag according to that pin's sense mode. The flag is sticky for the edge modes and follows the pin for the level modes. A pin raises its request only while it is pending, unmasked and given a nonzero priority. A combined request output is the OR of all per-pin requests.

Software reaches the block through a flat register bus with a write strobe, a small address and a 32-bit data word. Reads are combinational from the address. There are five registers, in this address order:

- Address 0: sense configuration.
- Address 1: priority.
- Address 2: source (pending status and acknowledge).
- Address 3: mask set (write-only).
- Address 4: mask clear (write-only).

Configuration fields are packed from the most significant end, so pin 0 owns the top field. Per-pin bits in the 8-bit registers also start at bit 7 for pin 0.

Top module: `xpin_irq_ctrl`

## Requirements
- R1: After reset the sense and priority registers read 0, the source register reads 0, every pin is masked, and `irq_o` and `irq_any_o` are 0.
- R2: The sense register (address 0) and the priority register (address 1) are 32-bit read-write registers that read back what was written. Pin n's sense field is SENSE_W bits wide (4 by default) at bit 32-(n+1)*SENSE_W. Pin n's priority field is 4 bits wide at bit 32-(n+1)*4.
- R3: Sense code 0 sets pin n's pending bit on a falling edge of the pin. Code 1 sets it on a rising edge, and code 4 sets it on either edge. The bit stays set until it is acknowledged.
- R4: Sense code 2 (active low) and code 3 (active high) make the pending bit follow the active pin level. While the level is active, an acknowledge write cannot clear the bit. The bit drops once the level becomes inactive.
- R5: Sense codes 5 to 15 detect nothing: pin changes never set the pending bit.
- R6: Reading address 2 returns pin n's pending bit at bit 7-n, with the upper bits 0. Writing address 2 with bit 7-n at 0 clears pin n's pending bit in the edge and no-detect modes, and a 1 leaves it unchanged.
- R7: A write to address 3 masks every pin n whose bit 7-n is 1. A write to address 4 unmasks every pin n whose bit 7-n is 1. Zero bits have no effect, and both addresses read as 0.
- R8: `irq_o[n]` is 1 exactly when pin n is pending, unmasked and has a nonzero priority field. `irq_any_o` is the OR of all `irq_o` bits.
- R9: A pin change applied between clock edges shows as pending after the third following rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | External interrupt pins, bit n is pin n |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | REG_W | Write data |
| bus_rdata_o | output | REG_W | Read data for bus_addr_i (combinational) |
| irq_o | output | NPINS | Per-pin interrupt request, bit n is pin n |
| irq_any_o | output | 1 | OR of all per-pin requests |

## Verification
A wrong pending bit is visible through the source register at the next read. When the pin is unmasked and its priority is nonzero, the same bit shows on `irq_o` in the same cycle it is stored. A wrong mask or priority bit shows as a request that appears or vanishes on `irq_o` one cycle after the write that set it. A synchronizer or detector that is one stage short or long shows up as a pending bit one edge early or late against the three-edge rule.

// File: rtl/xpin_pkg.sv
package xpin_pkg;
  localparam int unsigned ADR_SENSE = 0;
  localparam int unsigned ADR_PRIO  = 1;
  localparam int unsigned ADR_SRC   = 2;
  localparam int unsigned ADR_MSET  = 3;
  localparam int unsigned ADR_MCLR  = 4;

  typedef enum logic [3:0] {
    SNS_FALL = 4'd0,
    SNS_RISE = 4'd1,
    SNS_LOW  = 4'd2,
    SNS_HIGH = 4'd3,
    SNS_BOTH = 4'd4
  } sense_e;
endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] cur_o,
  output logic [NPINS-1:0] prev_o
);
  logic [NPINS-1:0] s1_q, s2_q, prev_q;
  logic [NPINS-1:0] s1_d, s2_d, prev_d;

  always_comb begin
    s1_d   = pin_i;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  assign cur_o  = s2_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/xpin_detect.sv
module xpin_detect
  import xpin_pkg::*;
#(
  parameter int unsigned SENSE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cur_i,
  input  logic               prev_i,
  input  logic [SENSE_W-1:0] mode_i,
  input  logic               clr_i,
  output logic               pend_o
);
  logic [3:0] code;
  logic       edge_hit, lvl_mode, lvl_act;
  logic       pend_q, pend_d, pend_en;

  assign code = 4'(mode_i);

  always_comb begin
    edge_hit = 1'b0;
    lvl_mode = 1'b0;
    lvl_act  = 1'b0;
    case (code)
      SNS_FALL: edge_hit = prev_i & ~cur_i;
      SNS_RISE: edge_hit = ~prev_i & cur_i;
      SNS_BOTH: edge_hit = prev_i ^ cur_i;
      SNS_LOW:  begin lvl_mode = 1'b1; lvl_act = ~cur_i; end
      SNS_HIGH: begin lvl_mode = 1'b1; lvl_act = cur_i;  end
      default:  edge_hit = 1'b0;
    endcase
    if (lvl_mode) pend_d = lvl_act;
    else          pend_d = (pend_q & ~clr_i) | edge_hit;
    pend_en = (pend_d != pend_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/xpin_regs.sv
module xpin_regs
  import xpin_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [NPINS-1:0]  pend_i,
  output logic [REG_W-1:0]  sense_o,
  output logic [REG_W-1:0]  prio_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  ack_clr_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] sense_q, prio_q;
  logic [NPINS-1:0] mask_q, mask_d;
  logic             sense_en, prio_en, mask_en;
  logic             sel_sense, sel_prio, sel_src, sel_mset, sel_mclr;
  logic [NPINS-1:0] pin_sel;
  logic [SRC_W-1:0] src_rd;

  assign sel_sense = (addr_i == ADDR_W'(ADR_SENSE));
  assign sel_prio  = (addr_i == ADDR_W'(ADR_PRIO));
  assign sel_src   = (addr_i == ADDR_W'(ADR_SRC));
  assign sel_mset  = (addr_i == ADDR_W'(ADR_MSET));
  assign sel_mclr  = (addr_i == ADDR_W'(ADR_MCLR));

  // per-pin bit of an 8-bit register, pin 0 at the top bit
  for (genvar n = 0; n < NPINS; n++) begin : g_map
    assign pin_sel[n]   = wdata_i[SRC_W-1-n];
    assign ack_clr_o[n] = wr_i & sel_src & ~wdata_i[SRC_W-1-n];
  end

  always_comb begin
    src_rd = '0;
    for (int n = 0; n < NPINS; n++) src_rd[SRC_W-1-n] = pend_i[n];
  end

  always_comb begin
    sense_en = wr_i & sel_sense;
    prio_en  = wr_i & sel_prio;
    mask_en  = wr_i & (sel_mset | sel_mclr);
    if (sel_mset) mask_d = mask_q | pin_sel;
    else          mask_d = mask_q & ~pin_sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      prio_q  <= '0;
      mask_q  <= '1;
    end else begin
      if (sense_en) sense_q <= wdata_i;
      if (prio_en)  prio_q  <= wdata_i;
      if (mask_en)  mask_q  <= mask_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_sense)     rdata_o = sense_q;
    else if (sel_prio) rdata_o = prio_q;
    else if (sel_src)  rdata_o = REG_W'(src_rd);
  end

  assign sense_o = sense_q;
  assign prio_o  = prio_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/xpin_irq_ctrl.sv
module xpin_irq_ctrl
  import xpin_pkg::*;
#(
  parameter int unsigned NPINS   = 8,
  parameter int unsigned SENSE_W = 4,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned REG_W   = 32,
  parameter int unsigned SRC_W   = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic [NPINS-1:0]  irq_o,
  output logic              irq_any_o
);
  logic [NPINS-1:0] cur_s, prev_s, pend_w, ack_clr, mask_q;
  logic [REG_W-1:0] sense_q, prio_q;

  xpin_sync #(.NPINS(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .cur_o  (cur_s),
    .prev_o (prev_s)
  );

  xpin_regs #(
    .NPINS (NPINS),
    .REG_W (REG_W),
    .SRC_W (SRC_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .pend_i   (pend_w),
    .sense_o  (sense_q),
    .prio_o   (prio_q),
    .mask_o   (mask_q),
    .ack_clr_o(ack_clr),
    .rdata_o  (bus_rdata_o)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    localparam int unsigned SLO = REG_W - (n + 1) * SENSE_W;
    localparam int unsigned PLO = REG_W - (n + 1) * PRIO_W;
    logic prio_ok;

    xpin_detect #(.SENSE_W(SENSE_W)) u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cur_i (cur_s[n]),
      .prev_i(prev_s[n]),
      .mode_i(sense_q[SLO +: SENSE_W]),
      .clr_i (ack_clr[n]),
      .pend_o(pend_w[n])
    );

    assign prio_ok  = |prio_q[PLO +: PRIO_W];
    assign irq_o[n] = pend_w[n] & ~mask_q[n] & prio_ok;
  end

  assign irq_any_o = |irq_o;
endmodule

// File: rtl/xpin_irq_chk.sv
module xpin_irq_chk #(
  parameter int unsigned NPINS   = 8,
  parameter int unsigned SENSE_W = 4,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned REG_W   = 32,
  parameter int unsigned SRC_W   = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [REG_W-1:0]  bus_wdata_i,
  input logic [NPINS-1:0]  irq_o,
  input logic              irq_any_o,
  input logic [NPINS-1:0]  pend_w,
  input logic [REG_W-1:0]  sense_q,
  input logic [REG_W-1:0]  prio_q
);
  logic [NPINS-1:0] wsel, prio_nz;

  always_comb begin
    for (int n = 0; n < NPINS; n++) begin
      wsel[n]    = bus_wdata_i[SRC_W-1-n];
      prio_nz[n] = (prio_q[REG_W-(n+1)*PRIO_W +: PRIO_W] != '0);
    end
  end

  // R7
  mask_set_kills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == ADDR_W'(3)) |=> ((irq_o & $past(wsel)) == '0));

  // R8
  any_is_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any_o == (irq_o != '0));

  // R8
  prio_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~prio_nz) == '0);

  // R8
  irq_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~pend_w) == '0);

  for (genvar n = 0; n < NPINS; n++) begin : g_quiet
    logic [3:0] code;
    assign code = 4'(sense_q[REG_W-(n+1)*SENSE_W +: SENSE_W]);
    // R5
    invalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code > 4'd4 && !pend_w[n] && !bus_wr_i) |=> !pend_w[n]);
  end
endmodule

bind xpin_irq_ctrl xpin_irq_chk #(
  .NPINS  (NPINS),
  .SENSE_W(SENSE_W),
  .PRIO_W (PRIO_W),
  .REG_W  (REG_W),
  .SRC_W  (SRC_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_wr_i   (bus_wr_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .irq_o      (irq_o),
  .irq_any_o  (irq_any_o),
  .pend_w     (pend_w),
  .sense_q    (sense_q),
  .prio_q     (prio_q)
);

// File: tb/sim_xpin_irq_ctrl.sv
`timescale 1ns/1ps
module sim_xpin_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin = '0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;
  logic        irq_any;

  int n_checks = 0;
  int n_errors = 0;

  logic [31:0] m_sense = '0, m_prio = '0;
  logic [7:0]  m_mask = 8'hFF, m_pend = '0, m_pin = '0;

  always #4 clk = ~clk;

  xpin_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .irq_any_o(irq_any)
  );

  function automatic logic [3:0] fld(input logic [31:0] w, input int n);
    return w[28-4*n +: 4];
  endfunction

  function automatic logic [7:0] exp_irq();
    logic [7:0] r;
    for (int n = 0; n < 8; n++)
      r[n] = m_pend[n] & ~m_mask[n] & (fld(m_prio, n) != 4'd0);
    return r;
  endfunction

  function automatic logic [7:0] exp_src();
    logic [7:0] r;
    for (int n = 0; n < 8; n++) r[7-n] = m_pend[n];
    return r;
  endfunction

  task automatic level_refresh();
    for (int n = 0; n < 8; n++) begin
      if (fld(m_sense, n) == 4'd2) m_pend[n] = ~m_pin[n];
      if (fld(m_sense, n) == 4'd3) m_pend[n] = m_pin[n];
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    rd_reg(3'd2, d);
    check({tag, " source"}, d, {24'd0, exp_src()});
    check({tag, " irq"}, {24'd0, irq}, {24'd0, exp_irq()});
    check({tag, " irq_any"}, {31'd0, irq_any}, {31'd0, |exp_irq()});
  endtask

  task automatic t_pins(input logic [7:0] v);
    @(negedge clk);
    pin = v;
    repeat (5) @(negedge clk);
    for (int n = 0; n < 8; n++) begin
      case (fld(m_sense, n))
        4'd0: if (m_pin[n] && !v[n]) m_pend[n] = 1'b1;
        4'd1: if (!m_pin[n] && v[n]) m_pend[n] = 1'b1;
        4'd4: if (m_pin[n] != v[n]) m_pend[n] = 1'b1;
        default: ;
      endcase
    end
    m_pin = v;
    level_refresh();
  endtask

  task automatic t_sense(input logic [31:0] w);
    wr_reg(3'd0, w); m_sense = w; level_refresh();
  endtask

  task automatic t_prio(input logic [31:0] w);
    wr_reg(3'd1, w); m_prio = w;
  endtask

  task automatic t_mset(input logic [7:0] w);
    wr_reg(3'd3, {24'd0, w});
    for (int n = 0; n < 8; n++) if (w[7-n]) m_mask[n] = 1'b1;
  endtask

  task automatic t_mclr(input logic [7:0] w);
    wr_reg(3'd4, {24'd0, w});
    for (int n = 0; n < 8; n++) if (w[7-n]) m_mask[n] = 1'b0;
  endtask

  task automatic t_ack(input logic [7:0] w);
    wr_reg(3'd2, {24'hFFFFFF, w});
    for (int n = 0; n < 8; n++) begin
      if (fld(m_sense, n) != 4'd2 && fld(m_sense, n) != 4'd3 && !w[7-n])
        m_pend[n] = 1'b0;
    end
    level_refresh();
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd_reg(3'd0, d); check("R1 sense reset", d, 32'd0);
    rd_reg(3'd1, d); check("R1 prio reset", d, 32'd0);
    check_all("R1 reset");
    t_prio(32'hFFFF_FFFF);
    t_pins(8'h01);
    check_all("R1 all masked after reset");
    t_pins(8'h00);
    t_ack(8'h00);

    // R2 readback and field placement
    t_sense(32'h0123_4501);
    rd_reg(3'd0, d); check("R2 sense readback", d, 32'h0123_4501);
    t_sense(32'h1000_0000);
    t_prio(32'hF000_0000);
    rd_reg(3'd1, d); check("R2 prio readback", d, 32'hF000_0000);
    rd_reg(3'd3, d); check("R7 mask set reads zero", d, 32'd0);
    rd_reg(3'd4, d); check("R7 mask clear reads zero", d, 32'd0);
    t_mclr(8'h80);

    // R3 edges
    t_pins(8'h01); check_all("R3 rising on pin0");
    t_pins(8'h03); check_all("R3 falling mode ignores rise");
    t_pins(8'h01); check_all("R3 falling on pin1, R8 prio zero");
    // R6 acknowledge
    t_ack(8'hBF); check_all("R6 ack pin1 only");
    t_ack(8'hFF); check_all("R6 all ones keeps");
    t_ack(8'h00); check_all("R6 all zeros clears");
    // R7 masking
    t_pins(8'h00); t_pins(8'h01); check_all("R7 unmasked request");
    t_mset(8'h80); check_all("R7 mask set pin0");
    t_mclr(8'h40); check_all("R7 other pin unmask");
    t_mclr(8'h80); check_all("R7 mask clear pin0");
    // R3 both edges on pin4
    t_sense(32'h1000_4000);
    t_prio(32'hFFFF_FFFF);
    t_mclr(8'hFF);
    t_pins(8'h11); check_all("R3 both rise");
    t_ack(8'hF7); check_all("R6 ack pin4");
    t_pins(8'h01); check_all("R3 both fall");
    t_ack(8'h00);
    // R4 levels
    t_sense(32'h1030_0000);
    t_pins(8'h05); check_all("R4 high level");
    t_ack(8'h00);  check_all("R4 ack while active");
    t_pins(8'h01); check_all("R4 level released");
    t_sense(32'h1032_0000); check_all("R4 low level active");
    t_pins(8'h09); check_all("R4 low level released");
    // R5 no-detect codes
    t_sense(32'h5678_9ABF);
    t_ack(8'h00);
    t_pins(8'hFF); check_all("R5 rise ignored");
    t_pins(8'h00); check_all("R5 fall ignored");
    // R9 latency
    t_sense(32'h1000_0000);
    t_ack(8'h00);
    @(negedge clk);
    pin = 8'h01;
    @(posedge clk); @(posedge clk);
    rd_reg(3'd2, d); check("R9 not yet pending", d, 32'd0);
    @(posedge clk);
    rd_reg(3'd2, d); check("R9 pending after third edge", d, 32'h80);
    repeat (3) @(negedge clk);
    m_pin = 8'h01; m_pend[0] = 1'b1;
    check_all("R9 settled");
    // R8 priority gate
    t_prio(32'h0FFF_FFFF); check_all("R8 prio zero silences");
    t_prio(32'h3FFF_FFFF); check_all("R8 prio nonzero");

    // R8 random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [31:0] w;
      op = $urandom % 6;
      case (op)
        0: t_pins(m_pin ^ 8'($urandom));
        1: begin
          for (int n = 0; n < 8; n++) w[28-4*n +: 4] = 4'($urandom % 8);
          t_sense(w);
        end
        2: begin
          for (int n = 0; n < 8; n++)
            w[28-4*n +: 4] = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom);
          t_prio(w);
        end
        3: t_mset(8'($urandom));
        4: t_mclr(8'($urandom));
        default: t_ack(8'($urandom));
      endcase
      check_all("R8 random");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule